// File: doc/BRIEF.md
# Interrupt Controller with Sleep Wake-Up

This block collects interrupt requests for a small microcontroller core and decides when the core has to branch to its interrupt routine. There are five request lines: a timer overflow pulse, a change detector on an 8-bit input port, two external request lines that trigger on a rising edge, and a comparator output that triggers on either edge. Each request can latch into a status flag only when its mask bit is set. A pending flag is a flag whose mask bit is also set. A pending flag raises an interrupt-taken request, which carries a fixed vector address, whenever the global enable is on.

Dedicated instruction strobes control the global enable: one enables, one disables, and the return-from-interrupt strobe enables again. Taking an interrupt clears the global enable. A sleep strobe parks the block. While it is asleep, only a pending port-change flag wakes it. If the global enable is on at that moment, the wake also vectors; if it is off, the core resumes in line.

Software reads and writes the status and mask registers through a one-address-bit register port. It refreshes the port-change reference with a port-read strobe.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, all flags, the mask, the global enable and the sleep state are cleared. `irqTake` and `wakeUp` are low, and both registers read 0.
- R2: Flag bit positions are fixed: bit 0 is the timer pulse, bit 1 is the port change, bit 2 is a rising edge on `extReq[0]`, bit 3 is a rising edge on `extReq[1]`, and bit 4 is any change of `cmpOut`. A falling edge on `extReq` sets nothing.
- R3: A flag is set at the clock edge where its event is seen, provided its mask bit is 1, whatever the global enable. An event whose mask bit is 0 sets nothing.
- R4: A port-read strobe copies `portIn` into a reference register. While any pin differs from that reference, the port change event is active.
- R5: With `regAddr`=0 the read data is flags AND mask. With `regAddr`=1 the read data is the mask.
- R6: A write with `regAddr`=0 clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. A hardware set of a flag in the same cycle wins over the clear.
- R7: When the global enable is on, the block is awake and some flag is pending, `irqTake` is high and `irqVector` is 0x008. The global enable clears at the next edge, so `irqTake` lasts one cycle.
- R8: The enable strobe and the return strobe set the global enable, and the disable strobe clears it. A flag still pending when the return strobe fires triggers `irqTake` again.
- R9: The sleep strobe sets `sleeping`. While asleep, `irqTake` stays low and only a pending port-change flag raises `wakeUp`. `sleeping` clears at the edge after `wakeUp`.
- R10: A wake with the global enable off gives `wakeUp` without `irqTake`. A wake with the global enable on gives both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrOvf | input | 1 | Timer overflow pulse |
| portIn | input | 8 | Monitored input port |
| extReq | input | 2 | External request lines, rising edge |
| cmpOut | input | 1 | Comparator output, either edge |
| portRd | input | 1 | Port read strobe, refreshes the reference |
| regAddr | input | 1 | Register select: 0 status, 1 mask |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 5 | Register write data |
| regRdata | output | 5 | Register read data |
| eniStb | input | 1 | Global enable strobe |
| disiStb | input | 1 | Global disable strobe |
| retiStb | input | 1 | Return-from-interrupt strobe |
| sleepStb | input | 1 | Enter sleep strobe |
| irqTake | output | 1 | Interrupt-taken request |
| irqVector | output | 12 | Interrupt vector address |
| wakeUp | output | 1 | Wake from sleep |
| sleeping | output | 1 | Sleep state |
| intEnable | output | 1 | Global enable state |

## Verification
The hardest situation to reach is a wake from sleep while another masked flag is already pending and the global enable is on. At that point the sleep gating must suppress `irqTake` for the timer flag, and then release it in the same cycle that the port change raises `wakeUp`. The bench gets there in a fixed order: it clears the status, enables globally, enters sleep, fires the timer (expecting silence), and then toggles a port pin. The same path is then repeated with the global enable off to show the in-line resume.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic refCapture;
  } ctrlStb_t;

  localparam int unsigned SRC_TMR  = 0;
  localparam int unsigned SRC_PORT = 1;
  localparam int unsigned SRC_EXT0 = 2;
endpackage

// File: rtl/irq_wake_path.sv
module irq_wake_path
  import irq_wake_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned EXT_N  = 2,
  parameter int unsigned NSRC   = EXT_N + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [NSRC-1:0]   wrData,
  input  logic              tmrOvf,
  input  logic [PORT_W-1:0] portIn,
  input  logic [EXT_N-1:0]  extReq,
  input  logic              cmpOut,
  output logic [NSRC-1:0]   maskOut,
  output logic [NSRC-1:0]   pendVec
);
  localparam int unsigned CMP_BIT = NSRC - 1;

  logic [PORT_W-1:0] refQ;
  logic [EXT_N-1:0]  extPrev;
  logic              cmpPrev;
  logic [NSRC-1:0]   flagQ, maskQ, rawEvt, setVec, keepVec, flagD;

  assign rawEvt[SRC_TMR]  = tmrOvf;
  assign rawEvt[SRC_PORT] = |(portIn ^ refQ);
  assign rawEvt[CMP_BIT]  = cmpOut ^ cmpPrev;

  for (genvar g = 0; g < EXT_N; g++) begin : g_ext
    assign rawEvt[SRC_EXT0 + g] = extReq[g] & ~extPrev[g];
  end

  assign setVec  = rawEvt & maskQ;
  assign keepVec = stb.wrStatus ? wrData : '1;
  assign flagD   = (flagQ & keepVec) | setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= '0;
      maskQ   <= '0;
      refQ    <= '0;
      extPrev <= '0;
      cmpPrev <= 1'b0;
    end else begin
      flagQ   <= flagD;
      extPrev <= extReq;
      cmpPrev <= cmpOut;
      if (stb.wrMask)     maskQ <= wrData;
      if (stb.refCapture) refQ  <= portIn;
    end
  end

  assign maskOut = maskQ;
  assign pendVec = flagQ & maskQ;

  // R3 R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((flagQ & $past(setVec)) == $past(setVec)));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & ~$past(flagQ) & ~$past(maskQ)) == '0));

  // R4
  ref_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.refCapture |=> (refQ == $past(portIn)));
endmodule

// File: rtl/irq_wake_seq.sv
module irq_wake_seq
  import irq_wake_pkg::*;
#(
  parameter int unsigned NSRC = 5,
  parameter logic [NSRC-1:0] WAKE_SRC = NSRC'(2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regAddr,
  input  logic            regWr,
  input  logic            portRd,
  input  logic            eniStb,
  input  logic            disiStb,
  input  logic            retiStb,
  input  logic            sleepStb,
  input  logic [NSRC-1:0] pendVec,
  output ctrlStb_t        stb,
  output logic            irqTake,
  output logic            wakeUp,
  output logic            gieOut,
  output logic            asleepOut
);
  logic gieQ, asleepQ, anyPend, wakeNow;

  assign stb.wrStatus   = regWr & ~regAddr;
  assign stb.wrMask     = regWr & regAddr;
  assign stb.refCapture = portRd;

  assign anyPend = |pendVec;
  assign wakeNow = asleepQ & (|(pendVec & WAKE_SRC));
  assign irqTake = gieQ & anyPend & (~asleepQ | wakeNow);
  assign wakeUp  = wakeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gieQ    <= 1'b0;
      asleepQ <= 1'b0;
    end else begin
      if (irqTake)                gieQ <= 1'b0;
      else if (eniStb | retiStb)  gieQ <= 1'b1;
      else if (disiStb)           gieQ <= 1'b0;

      if (wakeNow)       asleepQ <= 1'b0;
      else if (sleepStb) asleepQ <= 1'b1;
    end
  end

  assign gieOut    = gieQ;
  assign asleepOut = asleepQ;

  // R7
  take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |=> !gieQ);

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (asleepQ && !wakeUp) |-> !irqTake);

  // R9
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |=> !asleepQ);

  // R8
  enable_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((eniStb || retiStb) && !irqTake) |=> gieQ);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned EXT_N    = 2,
  parameter int unsigned VEC_W    = 12,
  parameter logic [VEC_W-1:0] VEC_ADDR = 12'h008,
  localparam int unsigned NSRC    = EXT_N + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrOvf,
  input  logic [PORT_W-1:0] portIn,
  input  logic [EXT_N-1:0]  extReq,
  input  logic              cmpOut,
  input  logic              portRd,
  input  logic              regAddr,
  input  logic              regWr,
  input  logic [NSRC-1:0]   regWdata,
  output logic [NSRC-1:0]   regRdata,
  input  logic              eniStb,
  input  logic              disiStb,
  input  logic              retiStb,
  input  logic              sleepStb,
  output logic              irqTake,
  output logic [VEC_W-1:0]  irqVector,
  output logic              wakeUp,
  output logic              sleeping,
  output logic              intEnable
);
  localparam logic [NSRC-1:0] WAKE_SRC = NSRC'(1) << SRC_PORT;

  ctrlStb_t        stb;
  logic [NSRC-1:0] maskQ, pendVec;

  irq_wake_seq #(.NSRC(NSRC), .WAKE_SRC(WAKE_SRC)) uSeq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .portRd(portRd), .eniStb(eniStb), .disiStb(disiStb),
    .retiStb(retiStb), .sleepStb(sleepStb), .pendVec(pendVec),
    .stb(stb), .irqTake(irqTake), .wakeUp(wakeUp),
    .gieOut(intEnable), .asleepOut(sleeping)
  );

  irq_wake_path #(.PORT_W(PORT_W), .EXT_N(EXT_N), .NSRC(NSRC)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWdata),
    .tmrOvf(tmrOvf), .portIn(portIn), .extReq(extReq), .cmpOut(cmpOut),
    .maskOut(maskQ), .pendVec(pendVec)
  );

  assign regRdata  = regAddr ? maskQ : pendVec;
  assign irqVector = VEC_ADDR;

  // R5
  read_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> ((regRdata & ~maskQ) == '0));
endmodule

// File: tb/tb_irq_wake_ctrl.sv
module tb_irq_wake_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic tmrOvf = 0, cmpOut = 0, portRd = 0, regAddr = 0, regWr = 0;
  logic [7:0] portIn = '0;
  logic [1:0] extReq = '0;
  logic [4:0] regWdata = '0, regRdata;
  logic eniStb = 0, disiStb = 0, retiStb = 0, sleepStb = 0;
  logic irqTake, wakeUp, sleeping, intEnable;
  logic [11:0] irqVector;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_wake_ctrl dut (
    .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .portIn(portIn), .extReq(extReq),
    .cmpOut(cmpOut), .portRd(portRd), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .eniStb(eniStb),
    .disiStb(disiStb), .retiStb(retiStb), .sleepStb(sleepStb),
    .irqTake(irqTake), .irqVector(irqVector), .wakeUp(wakeUp),
    .sleeping(sleeping), .intEnable(intEnable)
  );

  // entry: {mask[4:0], kind[2:0], expected status[4:0]}
  // kind 0 timer, 1 port toggle, 2 ext0 rise, 3 ext1 rise, 4 cmp toggle, 5 ext0 fall
  localparam logic [12:0] VECS [10] = '{
    {5'h1F, 3'd0, 5'h01}, {5'h1E, 3'd0, 5'h00}, {5'h02, 3'd1, 5'h02},
    {5'h1D, 3'd1, 5'h00}, {5'h04, 3'd2, 5'h04}, {5'h08, 3'd3, 5'h08},
    {5'h10, 3'd4, 5'h10}, {5'h1F, 3'd4, 5'h10}, {5'h1F, 3'd5, 5'h00},
    {5'h08, 3'd2, 5'h00}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [4:0] d);
    regAddr = a; regWr = 1'b1; regWdata = d;
    tick();
    regWr = 1'b0; regAddr = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [4:0] d);
    regAddr = a; #1; d = regRdata; regAddr = 1'b0;
  endtask

  task automatic refresh();
    portRd = 1'b1; tick(); portRd = 1'b0;
  endtask

  task automatic pulseTmr();
    tmrOvf = 1'b1; tick(); tmrOvf = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] rd;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    readReg(1'b0, rd); check("R1 status", 12'(rd), 12'h0);
    readReg(1'b1, rd); check("R1 mask", 12'(rd), 12'h0);
    check("R1 irqTake", 12'(irqTake), 12'h0);
    check("R1 wakeUp", 12'(wakeUp), 12'h0);
    check("R1 sleep/gie", 12'({sleeping, intEnable}), 12'h0);

    // R2 R3 R4 table walk, global enable off
    for (int i = 0; i < 10; i++) begin
      logic [4:0] m, e;
      logic [2:0] k;
      {m, k, e} = VECS[i];
      writeReg(1'b1, m);
      refresh();
      writeReg(1'b0, 5'h00);
      case (k)
        3'd0: pulseTmr();
        3'd1: begin portIn[i % 8] = ~portIn[i % 8]; tick(); end
        3'd2: begin extReq[0] = 1'b1; tick(); extReq[0] = 1'b0; end
        3'd3: begin extReq[1] = 1'b1; tick(); extReq[1] = 1'b0; end
        3'd4: begin cmpOut = ~cmpOut; tick(); end
        default: begin
          extReq[0] = 1'b1; tick(); tick();
          writeReg(1'b0, 5'h00);
          extReq[0] = 1'b0; tick();
        end
      endcase
      readReg(1'b0, rd);
      check($sformatf("R2 R3 vec%0d", i), 12'(rd), 12'(e));
      check($sformatf("R3 vec%0d no take", i), 12'(irqTake), 12'h0);
      refresh();
      writeReg(1'b0, 5'h00);
    end

    // R4 multi-pin change against stale reference
    writeReg(1'b1, 5'h02);
    refresh(); writeReg(1'b0, 5'h00);
    portIn = portIn ^ 8'hC3; tick();
    readReg(1'b0, rd); check("R4 multi-pin", 12'(rd), 12'h02);
    refresh(); writeReg(1'b0, 5'h00);
    tick();
    readReg(1'b0, rd); check("R4 reference refreshed", 12'(rd), 12'h00);

    // R5 readback is AND of flag and mask
    writeReg(1'b1, 5'h1F); pulseTmr();
    writeReg(1'b1, 5'h1E);
    readReg(1'b0, rd); check("R5 masked readback", 12'(rd), 12'h00);
    readReg(1'b1, rd); check("R5 mask read", 12'(rd), 12'h1E);
    writeReg(1'b1, 5'h1F);
    readReg(1'b0, rd); check("R5 flag retained", 12'(rd), 12'h01);

    // R6 write-one keeps, set wins over clear
    writeReg(1'b0, 5'h1F);
    readReg(1'b0, rd); check("R6 write one keeps", 12'(rd), 12'h01);
    writeReg(1'b0, 5'h00);
    readReg(1'b0, rd); check("R6 write zero clears", 12'(rd), 12'h00);
    tmrOvf = 1'b1; writeReg(1'b0, 5'h00); tmrOvf = 1'b0;
    readReg(1'b0, rd); check("R6 set wins", 12'(rd), 12'h01);
    writeReg(1'b0, 5'h00);

    // R7 take and vector
    writeReg(1'b1, 5'h01);
    eniStb = 1'b1; tick(); eniStb = 1'b0;
    check("R8 eni sets", 12'(intEnable), 12'h1);
    pulseTmr();
    check("R7 take", 12'(irqTake), 12'h1);
    check("R7 vector", irqVector, 12'h008);
    tick();
    check("R7 one cycle", 12'(irqTake), 12'h0);
    check("R7 gie cleared", 12'(intEnable), 12'h0);

    // R8 return / disable / retrigger
    writeReg(1'b0, 5'h00);
    retiStb = 1'b1; tick(); retiStb = 1'b0;
    check("R8 reti sets", 12'(intEnable), 12'h1);
    check("R8 no pending", 12'(irqTake), 12'h0);
    disiStb = 1'b1; tick(); disiStb = 1'b0;
    check("R8 disi clears", 12'(intEnable), 12'h0);
    pulseTmr();
    check("R8 gated off", 12'(irqTake), 12'h0);
    retiStb = 1'b1; tick(); retiStb = 1'b0;
    check("R8 retrigger", 12'(irqTake), 12'h1);
    tick();
    writeReg(1'b0, 5'h00);

    // R9 R10 sleep with global enable on
    writeReg(1'b1, 5'h03);
    refresh();
    eniStb = 1'b1; tick(); eniStb = 1'b0;
    sleepStb = 1'b1; tick(); sleepStb = 1'b0;
    check("R9 sleeping", 12'(sleeping), 12'h1);
    pulseTmr();
    check("R9 timer no wake", 12'({wakeUp, irqTake}), 12'h0);
    check("R9 still asleep", 12'(sleeping), 12'h1);
    portIn[2] = ~portIn[2]; tick();
    check("R10 wake gie on", 12'({wakeUp, irqTake}), 12'h3);
    tick();
    check("R9 awake", 12'({sleeping, wakeUp, irqTake}), 12'h0);
    refresh(); writeReg(1'b0, 5'h00);

    // R10 sleep with global enable off
    sleepStb = 1'b1; tick(); sleepStb = 1'b0;
    portIn[5] = ~portIn[5]; tick();
    check("R10 wake gie off", 12'({wakeUp, irqTake}), 12'h2);
    tick();
    check("R10 resume in line", 12'({sleeping, intEnable, irqTake}), 12'h0);
    refresh(); writeReg(1'b0, 5'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule